// File: doc/BRIEF.md
# Clock-Enable Configuration Slave (Two-Wire, Block Write)

This block is the configuration port of a clock fan-out buffer. It holds three 8-bit enable registers, one bit per buffered clock output, and lets a two-wire bus controller (I2C, standard mode, 100 kbit/s) load them and read them back. A fast system clock oversamples SCL and SDA. The block finds START and STOP conditions, matches its fixed 7-bit address, and pulls SDA low through an open-drain enable to acknowledge a byte or to send a zero bit.

The controller sends writes as block writes. The address byte is followed by two header bytes. The slave acknowledges both header bytes and drops their contents. The data bytes that follow go to register 0, then register 1, then register 2. The frame has no register pointer. A read begins at register 0 without any header and moves upward one register per byte. Every register comes out of reset at 0xFF, so all clock outputs start enabled.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset all three registers read 0xFF. cfg_o[8k+7:8k] is register k.
- R2: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read), which is 7-bit address 0x69 plus the R/W bit in bit 0. It acknowledges by raising sda_oe during the ninth SCL clock. Bytes are sent MSB first.
- R3: In a write, the slave acknowledges the first two bytes after the address and discards them. The later bytes go to registers 0, 1 and 2 in that order, and each register takes its value once its byte is complete.
- R4: A STOP after any complete byte ends the write. Registers already written keep their new values and the others keep their old ones.
- R5: A byte cut short by a STOP or START changes no register.
- R6: After any other address the slave does not acknowledge and ignores the bus until the next START.
- R7: A read returns register 0, then register 1, then register 2, each MSB first.
- R8: In a write, bytes past register 2 are acknowledged and dropped. In a read, bytes past register 2 read as 0xFF.
- R9: A repeated START restarts address matching, and a read that follows it sees data written earlier in the same frame.
- R10: When the controller NACKs a read byte, the slave releases SDA and drives nothing more until the next START.
- R11: sda_oe changes only while SCL is low, and it is released after a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_o | output | 24 | Enable registers 2..0, register 0 in the low byte |

## Verification
Two functions meet on the same frame: the register commit at the end of a data byte, and the read-data fetch at the acknowledge of a new address. The bench provokes this by writing a byte, issuing a repeated START straight away, and reading with address 0xD3. The value read back must be the byte just written and not the old contents. The bench also ends transfers with a STOP or START in the middle of a byte, next to complete bytes. The registers must change exactly at byte boundaries and nowhere else.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int IDX_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } link_state_e;

    // Synchronised line levels and the bus events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync
    import clkcfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [7:0]              rd_data,
    output logic [NUM_REGS*8-1:0]   cfg_o
);
    logic [7:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= 8'hFF;
            end else if (wr.we && wr.idx == IDX_W'(g)) begin
                regs[g] <= wr.data;
            end
        end
        assign cfg_o[g*8 +: 8] = regs[g];
    end

    // Indices past the last register read as all ones
    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = regs[k];
        end
    end
endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 3,
    parameter int         HDR_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output wr_req_t          wr,
    output logic             sda_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS);
    localparam logic [1:0]       HDR_N    = 2'(HDR_BYTES);

    link_state_e      state;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic             rw;
    logic [1:0]       hdr_cnt;
    logic [IDX_W-1:0] data_idx;
    logic             m_ack;

    assign rd_idx = data_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            hdr_cnt  <= '0;
            data_idx <= '0;
            m_ack    <= 1'b0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.we <= 1'b0;
            if (ev.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                data_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            if (addr_hit(shreg, DEV_ADDR)) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt  <= '0;
                            hdr_cnt <= '0;
                            if (rw) begin
                                state  <= ST_RD_BYTE;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                if (data_idx < LAST_IDX) data_idx <= data_idx + 1'b1;
                            end else begin
                                state  <= ST_WR_BYTE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            state  <= ST_WR_ACK;
                            if (hdr_cnt != HDR_N) begin
                                hdr_cnt <= hdr_cnt + 2'd1;
                            end else if (data_idx < LAST_IDX) begin
                                wr.we    <= 1'b1;
                                wr.idx   <= data_idx;
                                wr.data  <= shreg;
                                data_idx <= data_idx + 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            m_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (m_ack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                bitcnt <= '0;
                                state  <= ST_RD_BYTE;
                                if (data_idx < LAST_IDX) data_idx <= data_idx + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    bus_ev_t          ev;
    wr_req_t          wr;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;

    clkcfg_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    clkcfg_link #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .HDR_BYTES(2)) link_i (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr      (wr),
        .sda_oe  (sda_oe)
    );

    clkcfg_regs #(.NUM_REGS(NUM_REGS)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 3
) (
    input logic                  clk,
    input logic                  rst,
    input bus_ev_t               ev,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] cfg_o
);
    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_o == '1);

    // R3
    commit_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_o) |-> $past(ev.scl_fall, 2));

    // R5
    start_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |=> $stable(cfg_o));

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(ev.start) && !$past(ev.stop)) |-> !$past(ev.scl));

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);
endmodule

bind clkcfg_i2c_slave clkcfg_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .sda_oe (sda_oe),
    .cfg_o  (cfg_o)
);

// File: tb/clkcfg_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module clkcfg_i2c_slave_tb_top;
    localparam int Q = 100;

    typedef struct {
        string       req;
        logic [23:0] val;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic [23:0] cfg_o;
    logic        sda_line;

    exp_t        exp_q[$];
    exp_t        cur;
    logic [23:0] obs_val = '0;
    logic        obs_stb = 1'b0;
    int          checks = 0;
    int          fails = 0;
    logic        ack;
    logic [7:0]  rb;

    assign sda_line = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    clkcfg_i2c_slave dut_i (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .cfg_o  (cfg_o)
    );

    // Scoreboard monitor: pops one expectation per observed result
    always @(posedge obs_stb) begin
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected result: actual %h expected none", obs_val);
        end else begin
            cur = exp_q.pop_front();
            if (cur.val !== obs_val) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", cur.req, obs_val, cur.val);
            end
        end
    end

    task automatic expect_val(input string r, input logic [23:0] v);
        exp_t e;
        e.req = r;
        e.val = v;
        exp_q.push_back(e);
    endtask

    task automatic observe(input logic [23:0] v);
        obs_val = v;
        #1 obs_stb = 1'b1;
        #1 obs_stb = 1'b0;
        #3;
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; #Q;
        scl = 1'b1;   #Q;
        m_sda = 1'b0; #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; #Q;
        scl = 1'b1;   #Q;
        m_sda = 1'b1; #Q;
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; #Q;
        scl = 1'b1; #Q;
        #Q;
        scl = 1'b0; #Q;
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; #Q;
        scl = 1'b1; #Q;
        b = sda_line; #Q;
        scl = 1'b0; #Q;
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic a);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(s);
        a = ~s;
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic give_ack);
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        bit_out(~give_ack);
    endtask

    // Full write frame: address, two headers, then the data bytes
    task automatic write_frame(input logic [7:0] d0, input logic [7:0] d1,
                               input logic [7:0] d2, input int n, input string r);
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        i2c_start();
        wr_byte(8'hD2, ack); expect_val("R2", 24'd1); observe({23'd0, ack});
        wr_byte(8'hC7, ack); expect_val("R3", 24'd1); observe({23'd0, ack});
        wr_byte(8'h5E, ack); expect_val("R3", 24'd1); observe({23'd0, ack});
        for (int i = 0; i < n; i++) begin
            wr_byte(d[i], ack); expect_val(r, 24'd1); observe({23'd0, ack});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #50 rst = 1'b0;
        #50;
        // R1: reset defaults
        expect_val("R1", 24'hFFFFFF); observe(cfg_o);

        // R3: full write, headers dropped
        write_frame(8'hA5, 8'h3C, 8'h0F, 3, "R3");
        i2c_stop(); #Q;
        expect_val("R3", 24'h0F3CA5); observe(cfg_o);

        // R4: stop after one data byte
        write_frame(8'h55, 8'h00, 8'h00, 1, "R4");
        i2c_stop(); #Q;
        expect_val("R4", 24'h0F3C55); observe(cfg_o);

        // R5: stop in the middle of a data byte
        write_frame(8'h00, 8'h00, 8'h00, 0, "R5");
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        i2c_stop(); #Q;
        expect_val("R5", 24'h0F3C55); observe(cfg_o);

        // R5: start in the middle of the third header/data sequence
        write_frame(8'h00, 8'h00, 8'h00, 0, "R5");
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        i2c_start();
        i2c_stop(); #Q;
        expect_val("R5", 24'h0F3C55); observe(cfg_o);

        // R6: foreign address gets no ACK, following bytes ignored
        i2c_start();
        wr_byte(8'hA0, ack); expect_val("R6", 24'd0); observe({23'd0, ack});
        wr_byte(8'h00, ack); expect_val("R6", 24'd0); observe({23'd0, ack});
        wr_byte(8'h00, ack); wr_byte(8'h00, ack);
        expect_val("R6", 24'd0); observe({23'd0, ack});
        i2c_stop(); #Q;
        expect_val("R6", 24'h0F3C55); observe(cfg_o);

        // R8: write past the last register is acked and dropped
        write_frame(8'h12, 8'h34, 8'h00, 3, "R8");
        wr_byte(8'h99, ack); expect_val("R8", 24'd1); observe({23'd0, ack});
        i2c_stop(); #Q;
        expect_val("R8", 24'h003412); observe(cfg_o);

        // R7 / R8: read all registers plus one beyond
        i2c_start();
        wr_byte(8'hD3, ack); expect_val("R2", 24'd1); observe({23'd0, ack});
        rd_byte(rb, 1'b1); expect_val("R7", 24'h12); observe({16'd0, rb});
        rd_byte(rb, 1'b1); expect_val("R7", 24'h34); observe({16'd0, rb});
        rd_byte(rb, 1'b1); expect_val("R7", 24'h00); observe({16'd0, rb});
        rd_byte(rb, 1'b0); expect_val("R8", 24'hFF); observe({16'd0, rb});
        i2c_stop(); #Q;

        // R10: NACK on byte 1 stops transmission (register 2 is 0x00)
        i2c_start();
        wr_byte(8'hD3, ack); expect_val("R2", 24'd1); observe({23'd0, ack});
        rd_byte(rb, 1'b1); expect_val("R10", 24'h12); observe({16'd0, rb});
        rd_byte(rb, 1'b0); expect_val("R10", 24'h34); observe({16'd0, rb});
        rd_byte(rb, 1'b0); expect_val("R10", 24'hFF); observe({16'd0, rb});
        i2c_stop(); #Q;

        // R9: write then repeated START and read back the new value
        write_frame(8'h5A, 8'h00, 8'h00, 1, "R9");
        i2c_start();
        wr_byte(8'hD3, ack); expect_val("R9", 24'd1); observe({23'd0, ack});
        rd_byte(rb, 1'b0); expect_val("R9", 24'h5A); observe({16'd0, rb});
        i2c_stop(); #Q;
        expect_val("R9", 24'h00345A); observe(cfg_o);
        // R11: line released after STOP
        expect_val("R11", 24'd0); observe({23'd0, sda_oe});

        // R1: reset again restores defaults
        rst = 1'b1; #50 rst = 1'b0; #50;
        expect_val("R1", 24'hFFFFFF); observe(cfg_o);

        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule